// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the SDRAM command and address pins from reset until the memory is ready for normal traffic. It keeps the clock enable high and issues only no-operation commands for a long start-up delay. It then closes every bank with a single precharge-all, runs a configurable number of auto-refresh commands, and programs the mode register. After the mode register programming time has passed, it raises a done flag so that the normal controller can take over the pins.

All settings are elaboration-time parameters: the clock period, the start-up delay, the CAS latency, the burst length, the burst order and the refresh repeat count. The gaps after the precharge and after each refresh are taken from the CAS latency, because the spacing in cycles depends on the clock rate that goes with each latency. Every command is driven from a register, so command and address change one clock after the edge that decides them.

Top module: `sdram_powerup_seq`

## Requirements
- R1: While reset is asserted and before the first clock edge after reset: CKE high, a NOP on the pins ({cs_n,ras_n,cas_n,we_n} = 0111), address and bank all zero, every DQM bit high, and init_done low.
- R2: For the first S clock edges after reset, S = ceil(STARTUP_NS*1000 / CLK_PERIOD_PS), only NOP is driven.
- R3: A precharge-all (pins 0010) is driven after edge S, with address bit 10 high, every other address bit zero, and the bank lines zero.
- R4: The first auto-refresh (pins 0001) follows the precharge by tRP cycles: 3 cycles when CAS latency is 3 and 2 cycles when it is 2.
- R5: max(2, REFRESH_COUNT) auto-refresh commands are issued, each separated from the next command by tRC cycles: 10 at CAS latency 3, 6 at CAS latency 2. Only NOP appears between them.
- R6: The mode register set (pins 0000) follows the last refresh by tRC cycles, with the bank lines zero.
- R7: The mode word on the address lines holds the burst length code in bits 2:0 (1 word = 000, 2 = 001, 4 = 010, 8 = 011, full page = 111), the burst order in bit 3 (0 sequential, 1 interleaved), the CAS latency value in bits 6:4, and zero in all higher bits.
- R8: init_done rises exactly 2 cycles (tMRD) after the mode register set. It stays high until reset, and only NOP is driven from then on.
- R9: CKE stays high at all times. DQM stays all ones while init_done is low and drops to all zeros when init_done rises.
- R10: A reset that arrives in the middle of the sequence restarts the whole sequence from the start-up wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank select |
| sd_addr | output | ADDR_W | Address / mode word |
| sd_dqm | output | DQM_W | Data mask lines |
| init_done | output | 1 | Initialization finished |

## Verification
The bench builds two instances side by side. The first uses CAS latency 3, burst length 8, sequential order and two refreshes, so its gaps are 3 and 10 cycles and its mode word is 0x033. The second uses CAS latency 2, full-page interleaved bursts and three refreshes, so its gaps are 2 and 6 cycles and its mode word is 0x02F. Both use short start-up delays of 50 and 25 cycles, which puts the complete sequence, including a repeated refresh and a reset that lands mid-sequence, within a short run.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_PRE = 2'd1,
        CMD_REF = 2'd2,
        CMD_MRS = 2'd3
    } init_cmd_e;

    typedef enum logic [2:0] {
        ST_WAIT    = 3'd0,
        ST_PRE_GAP = 3'd1,
        ST_REF_GAP = 3'd2,
        ST_MRD_GAP = 3'd3,
        ST_DONE    = 3'd4
    } init_state_e;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Burst length in words to the 3-bit field code; 0 means full page.
    function automatic logic [2:0] burst_code(input int words);
        case (words)
            1:       return 3'b000;
            2:       return 3'b001;
            4:       return 3'b010;
            8:       return 3'b011;
            default: return 3'b111;
        endcase
    endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
    parameter int CNT_W     = 8,
    parameter int RESET_VAL = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= CNT_W'(RESET_VAL);
        else
            cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdram_mode_word.sv
module sdram_mode_word #(
    parameter int ADDR_W     = 13,
    parameter int CAS_LAT    = 3,
    parameter int BURST_LEN  = 8,
    parameter bit INTERLEAVE = 1'b0
) (
    output logic [ADDR_W-1:0] word
);
    import sdram_init_pkg::*;

    localparam logic [2:0] BL_FIELD = burst_code(BURST_LEN);
    localparam logic [2:0] CL_FIELD = 3'(CAS_LAT);

    always_comb begin
        word      = '0;
        word[2:0] = BL_FIELD;
        word[3]   = INTERLEAVE;
        word[6:4] = CL_FIELD;
    end

endmodule

// File: rtl/sdram_cmd_pins.sv
module sdram_cmd_pins (
    input  sdram_init_pkg::init_cmd_e cmd,
    output logic                      cs_n,
    output logic                      ras_n,
    output logic                      cas_n,
    output logic                      we_n
);
    import sdram_init_pkg::*;

    always_comb begin
        cs_n = 1'b0;
        case (cmd)
            CMD_PRE: {ras_n, cas_n, we_n} = 3'b010;
            CMD_REF: {ras_n, cas_n, we_n} = 3'b001;
            CMD_MRS: {ras_n, cas_n, we_n} = 3'b000;
            default: {ras_n, cas_n, we_n} = 3'b111;
        endcase
    end

endmodule

// File: rtl/sdram_powerup_seq.sv
module sdram_powerup_seq #(
    parameter int CLK_PERIOD_PS = 4000,
    parameter int STARTUP_NS    = 100000,
    parameter int CAS_LAT       = 3,
    parameter int BURST_LEN     = 8,
    parameter bit INTERLEAVE    = 1'b0,
    parameter int REFRESH_COUNT = 2,
    parameter int ADDR_W        = 13,
    parameter int BANK_W        = 2,
    parameter int DQM_W         = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [DQM_W-1:0]  sd_dqm,
    output logic              init_done
);
    import sdram_init_pkg::*;

    localparam int STARTUP_CYC = max2(1, ceil_div(STARTUP_NS * 1000, CLK_PERIOD_PS));
    localparam int T_RP        = (CAS_LAT == 3) ? 3 : 2;
    localparam int T_RC        = (CAS_LAT == 3) ? 10 : 6;
    localparam int T_MRD       = 2;
    localparam int REF_N       = max2(2, REFRESH_COUNT);
    localparam int REF_W       = $clog2(REF_N + 1);
    localparam int CNT_W       = $clog2(max2(STARTUP_CYC, T_RC) + 1);

    typedef struct packed {
        init_state_e       state;
        init_cmd_e         cmd;
        logic [ADDR_W-1:0] addr;
        logic [REF_W-1:0]  refs;
        logic              done;
    } seq_t;

    seq_t d, q;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic [ADDR_W-1:0] mode_word;

    sdram_init_timer #(
        .CNT_W     (CNT_W),
        .RESET_VAL (STARTUP_CYC - 1)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sdram_mode_word #(
        .ADDR_W     (ADDR_W),
        .CAS_LAT    (CAS_LAT),
        .BURST_LEN  (BURST_LEN),
        .INTERLEAVE (INTERLEAVE)
    ) u_mode (
        .word (mode_word)
    );

    always_comb begin
        d        = q;
        d.cmd    = CMD_NOP;
        d.addr   = '0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (q.state)
            ST_WAIT: begin
                if (tmr_expired) begin
                    d.cmd      = CMD_PRE;
                    d.addr[10] = 1'b1;
                    tmr_load   = 1'b1;
                    tmr_val    = CNT_W'(T_RP - 1);
                    d.state    = ST_PRE_GAP;
                end
            end
            ST_PRE_GAP: begin
                if (tmr_expired) begin
                    d.cmd    = CMD_REF;
                    d.refs   = REF_W'(1);
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(T_RC - 1);
                    d.state  = ST_REF_GAP;
                end
            end
            ST_REF_GAP: begin
                if (tmr_expired) begin
                    tmr_load = 1'b1;
                    if (q.refs == REF_W'(REF_N)) begin
                        d.cmd   = CMD_MRS;
                        d.addr  = mode_word;
                        tmr_val = CNT_W'(T_MRD - 1);
                        d.state = ST_MRD_GAP;
                    end else begin
                        d.cmd   = CMD_REF;
                        d.refs  = q.refs + 1'b1;
                        tmr_val = CNT_W'(T_RC - 1);
                    end
                end
            end
            ST_MRD_GAP: begin
                if (tmr_expired) begin
                    d.done  = 1'b1;
                    d.state = ST_DONE;
                end
            end
            default: d.done = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= ST_WAIT;
            q.cmd   <= CMD_NOP;
            q.addr  <= '0;
            q.refs  <= '0;
            q.done  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    sdram_cmd_pins u_pins (
        .cmd   (q.cmd),
        .cs_n  (sd_cs_n),
        .ras_n (sd_ras_n),
        .cas_n (sd_cas_n),
        .we_n  (sd_we_n)
    );

    assign sd_cke    = 1'b1;
    assign sd_ba     = '0;
    assign sd_addr   = q.addr;
    assign sd_dqm    = {DQM_W{~q.done}};
    assign init_done = q.done;

    // Precharge must close all banks.
    assert_pre_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_cs_n && !sd_ras_n && sd_cas_n && !sd_we_n) |-> sd_addr[10]);

    // Every refresh is followed by a NOP slot since tRC exceeds one cycle.
    assert_ref_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_cs_n && !sd_ras_n && !sd_cas_n && sd_we_n) |=> (sd_ras_n && sd_cas_n && sd_we_n));

    // Done never appears in the cycle right after the mode register set.
    assert_mrd_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_cs_n && !sd_ras_n && !sd_cas_n && !sd_we_n) |=> !init_done);

    // Done is sticky until reset.
    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    // Only NOPs once handed over.
    assert_nop_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (sd_ras_n && sd_cas_n && sd_we_n));

    // Refresh count never passes its target.
    assert_ref_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        q.refs <= REF_W'(REF_N));

endmodule

// File: tb/tb_sdram_powerup_seq.sv
`timescale 1ns/1ps
module tb_sdram_powerup_seq;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    // Instance A: CL3, BL8, sequential, 2 refreshes, 50-cycle start-up.
    localparam int SA = 50, RPA = 3, RCA = 10, NA = 2;
    localparam logic [12:0] MODE_A = 13'h033;
    // Instance B: CL2, full page, interleaved, 3 refreshes, 25-cycle start-up.
    localparam int SB = 25, RPB = 2, RCB = 6, NB = 3;
    localparam logic [12:0] MODE_B = 13'h02F;

    logic        a_cke, a_cs, a_ras, a_cas, a_we, a_done;
    logic [1:0]  a_ba, a_dqm;
    logic [12:0] a_addr;
    logic        b_cke, b_cs, b_ras, b_cas, b_we, b_done;
    logic [1:0]  b_ba, b_dqm;
    logic [12:0] b_addr;

    sdram_powerup_seq #(.CLK_PERIOD_PS(4000), .STARTUP_NS(200), .CAS_LAT(3),
        .BURST_LEN(8), .INTERLEAVE(1'b0), .REFRESH_COUNT(2)) dut (
        .clk(clk), .rst_n(rst_n), .sd_cke(a_cke), .sd_cs_n(a_cs), .sd_ras_n(a_ras),
        .sd_cas_n(a_cas), .sd_we_n(a_we), .sd_ba(a_ba), .sd_addr(a_addr),
        .sd_dqm(a_dqm), .init_done(a_done));

    sdram_powerup_seq #(.CLK_PERIOD_PS(4000), .STARTUP_NS(100), .CAS_LAT(2),
        .BURST_LEN(0), .INTERLEAVE(1'b1), .REFRESH_COUNT(3)) dut_cl2 (
        .clk(clk), .rst_n(rst_n), .sd_cke(b_cke), .sd_cs_n(b_cs), .sd_ras_n(b_ras),
        .sd_cas_n(b_cas), .sd_we_n(b_we), .sd_ba(b_ba), .sd_addr(b_addr),
        .sd_dqm(b_dqm), .init_done(b_done));

    int total = 0;
    int bad = 0;
    int edges = 0;
    int cycles = 0;
    bit restarted = 1'b0;

    // Edges seen since reset released (model of the reset behaviour).
    always @(posedge clk or negedge rst_n)
        if (!rst_n) edges <= 0;
        else        edges <= edges + 1;

    // 0 NOP, 1 PRE, 2 REF, 3 MRS
    function automatic int exp_code(int e, int s, int trp, int trc, int n);
        if (e == 0) return 0;
        if (e == s) return 1;
        for (int i = 0; i < n; i++)
            if (e == s + trp + i * trc) return 2;
        if (e == s + trp + n * trc) return 3;
        return 0;
    endfunction

    function automatic logic [3:0] code_pins(int c);
        case (c)
            1: return 4'b0010;
            2: return 4'b0001;
            3: return 4'b0000;
            default: return 4'b0111;
        endcase
    endfunction

    function automatic string cmd_tag(int c, int e, int s, int trp);
        if (e == 0) return "R1";
        if (restarted) return "R10";
        if (c == 1) return "R3";
        if (c == 2 && e == s + trp) return "R4";
        if (c == 2) return "R5";
        if (c == 3) return "R6";
        if (e < s) return "R2";
        return "R8";
    endfunction

    task automatic check(string tag, string what, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s at edge %0d: actual=%h expected=%h", tag, what, edges, got, exp);
        end
    endtask

    task automatic check_one(string nm, int s, int trp, int trc, int n, logic [12:0] mode,
                             logic cke, logic [3:0] pins, logic [1:0] ba,
                             logic [12:0] addr, logic [1:0] dqm, logic done);
        int c = exp_code(edges, s, trp, trc, n);
        logic [12:0] ea = (c == 1) ? 13'h0400 : (c == 3) ? mode : 13'h0000;
        logic ed = (edges >= s + trp + n * trc + 2);
        string t = cmd_tag(c, edges, s, trp);
        string ta = (c == 3 && !restarted) ? "R7" : t;
        string tr9 = (edges == 0) ? "R1" : "R9";
        check(t, {nm, " cmd"}, 32'(pins), 32'(code_pins(c)));
        check(ta, {nm, " addr"}, 32'(addr), 32'(ea));
        check(t, {nm, " bank"}, 32'(ba), 32'd0);
        check((edges == 0) ? "R1" : (restarted ? "R10" : "R8"), {nm, " done"}, 32'(done), 32'(ed));
        check(tr9, {nm, " cke"}, 32'(cke), 32'd1);
        check(tr9, {nm, " dqm"}, 32'(dqm), ed ? 32'd0 : 32'd3);
    endtask

    always @(negedge clk) begin
        cycles++;
        check_one("A", SA, RPA, RCA, NA, MODE_A, a_cke, {a_cs, a_ras, a_cas, a_we},
                  a_ba, a_addr, a_dqm, a_done);
        check_one("B", SB, RPB, RCB, NB, MODE_B, b_cke, {b_cs, b_ras, b_cas, b_we},
                  b_ba, b_addr, b_dqm, b_done);
    end

    task automatic set_reset(logic v);
        @(posedge clk);
        #1 rst_n = v;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        set_reset(1'b1);
        repeat (100) @(posedge clk);
        // Reset after completion, then again in the middle of the sequence.
        set_reset(1'b0);
        restarted = 1'b1;
        repeat (2) @(posedge clk);
        set_reset(1'b1);
        repeat (32) @(posedge clk);
        set_reset(1'b0);
        repeat (2) @(posedge clk);
        set_reset(1'b1);
        repeat (100) @(posedge clk);
        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #40000;
        total++;
        bad++;
        $display("FAIL watchdog expired at cycle %0d", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule